// File: doc/BRIEF.md
# Gated Period Timer

A free-running up-counter for a peripheral subsystem. A counter, `CNT_W` bits wide (32 by default), advances from the internal clock through a prescaler that divides by 1, 2, 4, 8, 16, 32, 64 or 256. When the count equals the period register, the next count step returns it to zero. This gives a repeating period. A simple synchronous register port loads the control word, the count and the period, and reads them back.

In plain mode each wrap produces a one-cycle match pulse. In gated mode an external gate input, resynchronised by two flops, enables counting. Counting runs while the synchronised gate is high. Wraps at the period still happen but raise no match pulse. A falling gate edge raises a one-cycle gate pulse and freezes the count where it stands. Software clears the count by writing it.

Top module: `gated_period_timer`

## Requirements
- R1: After reset the control word, the count and the period all read 0, and both event outputs are low.
- R2: The control word (address 0) keeps enable at bit 15, gate mode at bit 7, divider select at bits 6:4, wide-mode flag at bit 3 and clock-source flag at bit 1. All other bits read as 0. The count is at address 1 and the period at address 2.
- R3: Divider selects 0..6 give a ratio of 2^sel, and select 7 gives 256. After the enabling write, the count first advances N clocks later, then once every N clocks.
- R4: In plain mode, a step taken while the count equals the period loads 0 and drives the match output high for exactly that one cycle.
- R5: With a ratio N, the count stays at the period value for N clocks before it wraps to zero.
- R6: In gated mode the count advances only while the gate, delayed by a two-flop synchroniser, is high. A gate raised before edge G gives the first step at edge G+2.
- R7: In gated mode a wrap at the period raises no match pulse.
- R8: A falling synchronised gate edge in gated mode raises the gate output for one cycle, two edges after the gate is sampled low. The count holds its value.
- R9: A count write takes priority over a step in the same cycle and clears the prescaler. The next step therefore comes N clocks after the write.
- R10: While enable is 0 the count holds, the prescaler is cleared, and neither event output pulses. After re-enabling, the first step comes N clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_in | input | 1 | Asynchronous gate input |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Write address: 0 control, 1 count, 2 period |
| bus_wdata | input | CNT_W | Write data |
| bus_raddr | input | 2 | Read address, same map |
| bus_rdata | output | CNT_W | Read data (combinational) |
| match_evt | output | 1 | One-cycle period match pulse (plain mode) |
| gate_evt | output | 1 | One-cycle gate falling pulse (gated mode) |

## Verification
The bench builds the timer with its default `CNT_W` of 32 and uses small period values, so wraps come within a few cycles. Because the full divider range fits in the run, every ratio up to 256 is covered, including the hold at the period value at that ratio. A wrap of the full 32-bit range is out of reach; only short periods are exercised.

// File: rtl/gated_period_timer.sv
module gated_period_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_in,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  input  logic [1:0]       bus_raddr,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             match_evt,
  output logic             gate_evt
);
  localparam int PRE_W = 8;
  localparam logic [1:0] A_CTRL = 2'd0, A_CNT = 2'd1, A_PER = 2'd2;

  logic             ctl_on, ctl_gate, ctl_wide, ctl_src;
  logic [2:0]       ctl_div;
  logic [CNT_W-1:0] cnt, per, ctrl_word;
  logic [PRE_W-1:0] pre, pre_last;
  logic [2:0]       gsync;

  wire ctl_we    = bus_we && bus_addr == A_CTRL;
  wire cnt_we    = bus_we && bus_addr == A_CNT;
  wire per_we    = bus_we && bus_addr == A_PER;
  wire gate_hi   = gsync[1];
  wire gate_fall = !gsync[1] && gsync[2];
  wire run       = ctl_on && (!ctl_gate || gate_hi);
  wire tick      = run && pre >= pre_last;
  wire at_per    = cnt == per;

  always_comb begin
    if (ctl_div == 3'd7) pre_last = 8'd255;
    else                 pre_last = 8'((9'd1 << ctl_div) - 9'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_on <= 1'b0; ctl_gate <= 1'b0; ctl_wide <= 1'b0; ctl_src <= 1'b0;
      ctl_div <= '0;
    end else if (ctl_we) begin
      ctl_on   <= bus_wdata[15];
      ctl_gate <= bus_wdata[7];
      ctl_div  <= bus_wdata[6:4];
      ctl_wide <= bus_wdata[3];
      ctl_src  <= bus_wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      per <= '0;
    else if (per_we) per <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gsync <= '0;
    else        gsync <= {gsync[1:0], gate_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pre <= '0;
    else if (!ctl_on || cnt_we)  pre <= '0;
    else if (run)                pre <= tick ? '0 : pre + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (cnt_we)  cnt <= bus_wdata;
    else if (tick)    cnt <= at_per ? '0 : cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_evt <= 1'b0;
      gate_evt  <= 1'b0;
    end else begin
      match_evt <= tick && at_per && !ctl_gate && !cnt_we;
      gate_evt  <= ctl_on && ctl_gate && gate_fall;
    end
  end

  always_comb begin
    ctrl_word     = '0;
    ctrl_word[15] = ctl_on;
    ctrl_word[7]  = ctl_gate;
    ctrl_word[6:4]= ctl_div;
    ctrl_word[3]  = ctl_wide;
    ctrl_word[1]  = ctl_src;
    case (bus_raddr)
      A_CTRL:  bus_rdata = ctrl_word;
      A_CNT:   bus_rdata = cnt;
      A_PER:   bus_rdata = per;
      default: bus_rdata = '0;
    endcase
  end

  assert_match_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |-> cnt == '0);

  assert_step_by_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cnt_we) && cnt != $past(cnt)) |-> (cnt == $past(cnt) + CNT_W'(1) || cnt == '0));

  assert_off_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_on && !cnt_we) |=> cnt == $past(cnt));

  assert_off_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_on |=> (!match_evt && !gate_evt));

  assert_gate_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gate_evt |=> !gate_evt);

  assert_gate_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_evt && !$past(cnt_we)) |-> cnt == $past(cnt));
endmodule

// File: tb/gated_period_timer_tb.sv
module gated_period_timer_tb;
  localparam int CLK_NS = 10;
  localparam int W = 32;

  logic clk = 0, rst_n = 0, gate_in = 0, bus_we = 0;
  logic [1:0] bus_addr = 0, bus_raddr = 2'd1;
  logic [W-1:0] bus_wdata = 0, bus_rdata;
  logic match_evt, gate_evt;

  gated_period_timer #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .gate_in(gate_in), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_raddr(bus_raddr),
    .bus_rdata(bus_rdata), .match_evt(match_evt), .gate_evt(gate_evt));

  always #(CLK_NS/2) clk = ~clk;

  typedef struct { int at; int kind; logic [W-1:0] val; string tag; } exp_t;
  exp_t q[$];
  int edges = 0, compared = 0, mismatched = 0, last_w = 0;
  bit done = 0;

  always @(posedge clk) edges <= edges + 1;

  task automatic push(input int at, input int kind, input logic [W-1:0] val, input string tag);
    exp_t e;
    e.at = at; e.kind = kind; e.val = val; e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    exp_t e;
    logic [W-1:0] act;
    while (q.size() > 0 && q[0].at <= edges) begin
      e = q.pop_front();
      act = (e.kind == 0) ? bus_rdata : (e.kind == 1) ? W'(match_evt) : W'(gate_evt);
      compared++;
      if (act !== e.val || e.at != edges) begin
        mismatched++;
        $display("FAIL %s edge %0d kind %0d: got %0h expected %0h", e.tag, e.at, e.kind, act, e.val);
      end
    end
  end

  task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk); #1;
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 0;
    last_w = edges;
  endtask

  task automatic gate_set(input logic v);
    @(negedge clk); #1;
    gate_in = v;
    @(posedge clk); #1;
    last_w = edges;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    @(negedge clk); #2;
    bus_raddr = a; #1;
    d = bus_rdata;
    bus_raddr = 2'd1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [W-1:0] d;
    int w0, x0, y0, g0, hold;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: reset state
    rd(2'd0, d); chk(d, 0, "R1 control");
    rd(2'd1, d); chk(d, 0, "R1 count");
    rd(2'd2, d); chk(d, 0, "R1 period");
    chk(W'(match_evt), 0, "R1 match_evt");
    chk(W'(gate_evt), 0, "R1 gate_evt");

    // R2: field layout, unused bits read zero
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk(d, 32'h0000_80FA, "R2 control readback");
    wr(2'd0, 0); wr(2'd1, 0);
    wr(2'd2, 32'h1234_5678);
    rd(2'd2, d); chk(d, 32'h1234_5678, "R2 period readback");

    // R4: plain mode, N=1, period 3
    wr(2'd2, 3);
    wr(2'd0, 32'h8008); w0 = last_w;
    push(w0+1, 0, 1, "R4 count step");
    push(w0+3, 0, 3, "R4 at period");
    push(w0+3, 1, 0, "R4 no early match");
    push(w0+4, 0, 0, "R4 wrap");
    push(w0+4, 1, 1, "R4 match pulse");
    push(w0+5, 0, 1, "R4 after wrap");
    push(w0+5, 1, 0, "R4 match one cycle");
    drain();
    // R10: disable holds count
    wr(2'd0, 0); x0 = last_w;
    hold = (x0 - w0) % 4;
    push(x0+1, 0, W'(hold), "R10 hold");
    push(x0+10, 0, W'(hold), "R10 still held");
    push(x0+10, 1, 0, "R10 no match while off");
    drain();

    // R5: N=4, period 2
    wr(2'd1, 0);
    wr(2'd2, 2);
    wr(2'd0, 32'h8028); w0 = last_w;
    push(w0+3, 0, 0, "R3 N=4 before step");
    push(w0+4, 0, 1, "R3 N=4 first step");
    push(w0+8, 0, 2, "R5 reach period");
    push(w0+11, 0, 2, "R5 hold at period");
    push(w0+11, 1, 0, "R5 no match during hold");
    push(w0+12, 0, 0, "R5 wrap after hold");
    push(w0+12, 1, 1, "R5 match at wrap");
    drain();
    // R9: count write clears prescaler
    wait (edges == w0 + 13);
    wr(2'd1, 100); x0 = last_w;
    push(x0, 0, 100, "R9 write lands");
    push(x0+3, 0, 100, "R9 prescaler cleared");
    push(x0+4, 0, 101, "R9 step N after write");
    drain();
    // R9: write beats a coinciding step
    wait (edges == x0 + 7);
    wr(2'd1, 500); y0 = last_w;
    push(y0, 0, 500, "R9 write over step");
    push(y0+3, 0, 500, "R9 no step yet");
    push(y0+4, 0, 501, "R9 step after write");
    drain();
    // R10: disable clears prescaler
    wait (edges == y0 + 5);
    wr(2'd0, 0);
    wr(2'd0, 32'h8028); x0 = last_w;
    push(x0+3, 0, 501, "R10 prescaler restarted");
    push(x0+4, 0, 502, "R10 step N after re-enable");
    drain();

    // R3: ratios 2..64
    for (int s = 1; s <= 6; s++) begin
      int n;
      n = 1 << s;
      wr(2'd0, 0); wr(2'd1, 0); wr(2'd2, 1000);
      wr(2'd0, 32'h8000 | (s << 4)); w0 = last_w;
      push(w0+n-1, 0, 0, "R3 ratio before step");
      push(w0+n, 0, 1, "R3 ratio first step");
      push(w0+2*n, 0, 2, "R3 ratio second step");
      drain();
    end

    // R3/R5: select 7 is 256
    wr(2'd0, 0); wr(2'd1, 0); wr(2'd2, 1);
    wr(2'd0, 32'h8078); w0 = last_w;
    push(w0+255, 0, 0, "R3 div256 before step");
    push(w0+256, 0, 1, "R3 div256 step");
    push(w0+511, 0, 1, "R5 div256 hold");
    push(w0+512, 0, 0, "R5 div256 wrap");
    push(w0+512, 1, 1, "R4 div256 match");
    drain();

    // R6/R7/R8: gated mode, N=1, period 5
    wr(2'd0, 0); wr(2'd1, 0); wr(2'd2, 5);
    wr(2'd0, 32'h8080);
    repeat (5) @(negedge clk);
    rd(2'd1, d); chk(d, 0, "R6 gate low no count");
    gate_set(1'b1); g0 = last_w;
    push(g0+1, 0, 0, "R6 sync latency");
    push(g0+2, 0, 1, "R6 first gated step");
    push(g0+6, 0, 5, "R6 gated at period");
    push(g0+7, 0, 0, "R7 gated wrap");
    push(g0+7, 1, 0, "R7 no match in gated mode");
    wait (edges == g0 + 7);
    gate_set(1'b0); x0 = last_w;
    push(x0+1, 2, 0, "R8 no early gate pulse");
    push(x0+2, 2, 1, "R8 gate pulse");
    push(x0+2, 0, 2, "R8 count frozen");
    push(x0+3, 2, 0, "R8 gate pulse one cycle");
    push(x0+5, 0, 2, "R8 count still frozen");
    drain();

    done = 1;
    summary();
  end
endmodule